// File: doc/BRIEF.md
# Parallel Port Mode FIFO

This block is the byte queue between a host register interface and the data path of a parallel port. A 3-bit mode input and a direction bit in a small control register decide who may fill and who may drain the queue. In compatible FIFO mode, host bytes always flow toward the peripheral. In ECP data mode, the flow follows the direction bit. In test mode, the host both writes and reads the queue, and no byte ever reaches the peripheral side. The peripheral side is a plain strobe interface: a take strobe removes the head byte, and a put strobe appends a byte. Line handshake timing, DMA and bus decoding live elsewhere.

The block reports full, empty and a service request. The service request follows a drain threshold when the port sends and a fill threshold when it receives. It also latches an acknowledge interrupt on a rising edge of the active-low acknowledge line. Changing the mode flushes the queue. In test mode, overflow and underrun are harmless: a write to a full queue is lost, and a read from an empty queue repeats the last byte.

Top module: `ppm_fifo`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_full is 0, svc_irq is 0, ack_irq is 0, host_rdata is 00h and ctl_rdata is 00h. The captured-byte register starts at 00h.
- R2: The direction bit is control bit 5, where 1 means input. In modes 000 and 010 the bit is ignored and the port always sends. In every other mode it selects the direction.
- R3: In mode 010, each host_wr appends host_wdata. Each per_take removes the head, which per_data shows while per_valid is 1. host_rd has no effect.
- R4: In mode 011 with direction 0, the host fills the queue and the peripheral drains it. With direction 1, per_put appends per_put_data while per_room is 1, host_rd removes the head, and host_wr has no effect.
- R5: In mode 110, host_wr appends and host_rd removes, whatever the direction. per_valid and per_room stay 0, and per_take and per_put have no effect. In modes other than 010, 011 and 110, nothing enters or leaves the queue.
- R6: An append to a full queue is dropped and leaves the contents and count unchanged, even when a removal happens in the same cycle.
- R7: A host read of an empty queue leaves host_rdata at the last byte the host removed.
- R8: fifo_empty is 1 exactly when the queue holds 0 bytes. fifo_full is 1 exactly when it holds 16 bytes.
- R9: svc_irq is 1 in modes 010, 011 and 110 when the port sends and occupancy is 8 or less, or when the port receives and occupancy is 8 or more. In all other modes it is 0.
- R10: When control bit 4 is 1, a low-to-high change on ack_n sets ack_irq. The flag holds until the next control write clears it. A set in the same cycle as that write wins.
- R11: ctl_rdata bits 5:0 return the last written bits 5:0. Bits 7:6 always read 0.
- R12: A cycle in which mode_sel differs from the current mode empties the queue and performs no transfer.
- R13: host_rdata shows a removed byte from the clock edge that follows the host_rd cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Port mode |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 5 direction, bit 4 ack interrupt enable) |
| ctl_rdata | output | 8 | Control register read-back |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| host_rdata | output | 8 | Last byte removed by the host |
| per_take | input | 1 | Peripheral removes the head byte |
| per_valid | output | 1 | A byte is available to the peripheral |
| per_data | output | 8 | Head byte toward the peripheral |
| per_put | input | 1 | Peripheral appends a byte |
| per_put_data | input | 8 | Byte from the peripheral |
| per_room | output | 1 | Peripheral may append |
| ack_n | input | 1 | Active-low acknowledge line |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| svc_irq | output | 1 | Threshold service request |
| ack_irq | output | 1 | Latched acknowledge interrupt |

## Verification
The bench drives the block from writes into a full queue and keeps reading after the queue is empty in test mode. A design that corrupted the queue or overwrote the head would show a wrong byte order or a count above 16. A design that returned stale or garbage data would break the repeated last byte. It sets the direction bit to 1 in compatible mode and writes in mode 000, which catches a design that honours the direction bit or the host strobes where it must not. It walks occupancy across 8 in both directions, where swapping the two threshold rules or using a strict comparison shows up at once. It also changes the mode while the queue holds data, and it pulses the acknowledge line with the enable bit set and clear.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  localparam logic [2:0] PM_SPP    = 3'b000;
  localparam logic [2:0] PM_COMPAT = 3'b010;
  localparam logic [2:0] PM_ECP    = 3'b011;
  localparam logic [2:0] PM_TEST   = 3'b110;

  localparam int CTL_DIR_BIT = 5;
  localparam int CTL_IEN_BIT = 4;

  typedef struct packed {
    logic fifo_mode;
    logic fwd;
    logic host_wr_ok;
    logic host_rd_ok;
    logic per_take_ok;
    logic per_put_ok;
  } gate_t;

endpackage

// File: rtl/ppm_ctl_reg.sv
module ppm_ctl_reg
  import ppm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       ack_n,
  output logic [7:0] ctl_rdata,
  output logic       dir_in,
  output logic       ack_irq
);

  logic [5:0] ctl_q, ctl_d;
  logic       nack_q;
  logic       ack_q, ack_d;
  logic       ack_rise;
  logic       unused_wr_hi;

  assign unused_wr_hi = ^ctl_wdata[7:6];
  assign ack_rise     = ack_n & ~nack_q;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = ctl_wdata[5:0];
  end

  always_comb begin
    ack_d = ack_q;
    if (ctl_we) ack_d = 1'b0;
    if (ctl_q[CTL_IEN_BIT] && ack_rise) ack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      nack_q <= 1'b1;
      ack_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      nack_q <= ack_n;
      ack_q  <= ack_d;
    end
  end

  assign ctl_rdata = {2'b00, ctl_q};
  assign dir_in    = ctl_q[CTL_DIR_BIT];
  assign ack_irq   = ack_q;

  AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_rdata[CTL_IEN_BIT] && $rose(ack_n)) |=> ack_irq); // R10

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_irq && !ctl_we) |=> ack_irq); // R10

  AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_we |=> (ctl_rdata[5:0] == $past(ctl_wdata[5:0]))); // R11

endmodule

// File: rtl/ppm_mode_gate.sv
module ppm_mode_gate
  import ppm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [2:0] mode_sel,
  input  logic       dir_in,
  output logic       mode_clr,
  output gate_t      gate
);

  logic [2:0] mode_q;
  logic [2:0] mode_d;

  assign mode_clr = (mode_sel != mode_q);
  assign mode_d   = mode_sel;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_SPP;
    else         mode_q <= mode_d;
  end

  always_comb begin
    gate = '0;
    gate.fwd = 1'b1;
    case (mode_q)
      PM_COMPAT: begin
        gate.fifo_mode   = 1'b1;
        gate.host_wr_ok  = 1'b1;
        gate.per_take_ok = 1'b1;
      end
      PM_ECP: begin
        gate.fifo_mode   = 1'b1;
        gate.fwd         = ~dir_in;
        gate.host_wr_ok  = ~dir_in;
        gate.per_take_ok = ~dir_in;
        gate.host_rd_ok  = dir_in;
        gate.per_put_ok  = dir_in;
      end
      PM_TEST: begin
        gate.fifo_mode  = 1'b1;
        gate.fwd        = ~dir_in;
        gate.host_wr_ok = 1'b1;
        gate.host_rd_ok = 1'b1;
      end
      PM_SPP:  gate.fwd = 1'b1;
      default: gate.fwd = ~dir_in;
    endcase
  end

  AST_TEST_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == PM_TEST) |-> !(gate.per_take_ok || gate.per_put_ok)); // R5

  AST_FWD_FORCED: assert property (@(posedge clk) disable iff (!rst_ni)
    ((mode_q == PM_SPP) || (mode_q == PM_COMPAT)) |-> gate.fwd); // R2

  AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(gate.host_wr_ok && gate.per_put_ok)); // R4

endmodule

// File: rtl/ppm_fifo_core.sv
module ppm_fifo_core #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            clr,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic            pop_host,
  output logic [DW-1:0]   head,
  output logic [CNTW-1:0] count,
  output logic [DW-1:0]   last
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [AW-1:0]   PTR_TOP  = AW'(DEPTH - 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, wr_ptr_d;
  logic [AW-1:0]   rd_ptr, rd_ptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]   last_q, last_d;
  logic            is_full, is_empty, do_push, do_pop;

  assign is_full  = (cnt_q == FULL_CNT);
  assign is_empty = (cnt_q == '0);
  assign do_push  = push & ~is_full  & ~clr;
  assign do_pop   = pop  & ~is_empty & ~clr;
  assign head     = mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt_q;
    last_d   = last_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      if (do_pop && pop_host) last_d = mem[rd_ptr];
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign count = cnt_q;
  assign last  = last_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    count <= FULL_CNT); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && (count == FULL_CNT) && !pop && !clr) |=> $stable(count)); // R6

  AST_EMPTY_REREAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop && (count == '0) && !clr) |=> $stable(last)); // R7

  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count == '0)); // R12

endmodule

// File: rtl/ppm_fifo.sv
module ppm_fifo
  import ppm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          per_take,
  output logic          per_valid,
  output logic [DW-1:0] per_data,
  input  logic          per_put,
  input  logic [DW-1:0] per_put_data,
  output logic          per_room,
  input  logic          ack_n,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          svc_irq,
  output logic          ack_irq
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] WR_LIM   = CNTW'(WR_THR);
  localparam logic [CNTW-1:0] RD_LIM   = CNTW'(RD_THR);

  logic rst_meta, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic            dir_in, mode_clr;
  gate_t           gate;
  logic            push, pop, pop_host;
  logic [DW-1:0]   push_data;
  logic [CNTW-1:0] count;
  logic [DW-1:0]   head;

  ppm_ctl_reg u_ctl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ack_n     (ack_n),
    .ctl_rdata (ctl_rdata),
    .dir_in    (dir_in),
    .ack_irq   (ack_irq)
  );

  ppm_mode_gate u_gate (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .mode_sel (mode_sel),
    .dir_in   (dir_in),
    .mode_clr (mode_clr),
    .gate     (gate)
  );

  assign pop_host  = host_rd & gate.host_rd_ok;
  assign pop       = pop_host | (per_take & gate.per_take_ok);
  assign push      = (host_wr & gate.host_wr_ok) | (per_put & gate.per_put_ok);
  assign push_data = gate.per_put_ok ? per_put_data : host_wdata;

  ppm_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr       (mode_clr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_host  (pop_host),
    .head      (head),
    .count     (count),
    .last      (host_rdata)
  );

  always_comb begin
    fifo_full  = (count == FULL_CNT);
    fifo_empty = (count == '0);
    per_valid  = gate.per_take_ok & ~fifo_empty;
    per_room   = gate.per_put_ok & ~fifo_full;
    per_data   = head;
    svc_irq    = 1'b0;
    if (gate.fifo_mode) svc_irq = gate.fwd ? (count <= WR_LIM) : (count >= RD_LIM);
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(fifo_full && fifo_empty)); // R8

  AST_SVC_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !gate.fifo_mode |-> !svc_irq); // R9

endmodule

// File: tb/ppm_fifo_test.sv
module ppm_fifo_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       ctl_we;
  logic [7:0] ctl_wdata, ctl_rdata;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       per_take, per_valid, per_put, per_room;
  logic [7:0] per_data, per_put_data;
  logic       ack_n, fifo_full, fifo_empty, svc_irq, ack_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppm_fifo uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .per_take(per_take), .per_valid(per_valid), .per_data(per_data),
    .per_put(per_put), .per_put_data(per_put_data), .per_room(per_room),
    .ack_n(ack_n), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .svc_irq(svc_irq), .ack_irq(ack_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit chk_on = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] q[$];
  logic [7:0] m_last;
  logic [2:0] m_mode;
  logic [5:0] m_ctl;
  logic       m_nack, m_ack;

  function automatic bit m_fwd();
    return (m_mode == 3'b000 || m_mode == 3'b010) ? 1'b1 : !m_ctl[5];
  endfunction
  function automatic bit m_fifo_mode();
    return m_mode == 3'b010 || m_mode == 3'b011 || m_mode == 3'b110;
  endfunction
  function automatic bit m_take_ok();
    return m_mode == 3'b010 || (m_mode == 3'b011 && m_fwd());
  endfunction
  function automatic bit m_put_ok();
    return m_mode == 3'b011 && !m_fwd();
  endfunction
  function automatic bit m_hwr_ok();
    return m_mode == 3'b010 || m_mode == 3'b110 || (m_mode == 3'b011 && m_fwd());
  endfunction
  function automatic bit m_hrd_ok();
    return m_mode == 3'b110 || (m_mode == 3'b011 && !m_fwd());
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_last = 8'h00; m_mode = 3'b000; m_ctl = 6'h00;
      m_nack = 1'b1; m_ack = 1'b0;
    end else begin
      int pre;
      bit set;
      pre = q.size();
      set = m_ctl[4] && ack_n && !m_nack;
      if (ctl_we) m_ack = 1'b0;
      if (set) m_ack = 1'b1;
      m_nack = ack_n;
      if (mode_sel != m_mode) begin
        q.delete();
      end else begin
        if (((host_rd && m_hrd_ok()) || (per_take && m_take_ok())) && pre > 0) begin
          logic [7:0] v;
          v = q.pop_front();
          if (host_rd && m_hrd_ok()) m_last = v;
        end
        if (pre < 16) begin
          if (host_wr && m_hwr_ok()) q.push_back(host_wdata);
          else if (per_put && m_put_ok()) q.push_back(per_put_data);
        end
      end
      m_mode = mode_sel;
      if (ctl_we) m_ctl = ctl_wdata[5:0];
    end
  end

  task automatic expect8(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      bit e_svc, e_pv;
      e_svc = m_fifo_mode() && (m_fwd() ? (q.size() <= 8) : (q.size() >= 8));
      e_pv  = m_take_ok() && q.size() > 0;
      expect8(fifo_empty == (q.size() == 0), "R8 empty", {7'd0, fifo_empty}, {7'd0, q.size() == 0});
      expect8(fifo_full  == (q.size() == 16), "R8 full", {7'd0, fifo_full}, {7'd0, q.size() == 16});
      expect8(host_rdata == m_last, "R13 host_rdata", host_rdata, m_last);
      expect8(svc_irq == e_svc, "R9 svc_irq", {7'd0, svc_irq}, {7'd0, e_svc});
      expect8(ack_irq == m_ack, "R10 ack_irq", {7'd0, ack_irq}, {7'd0, m_ack});
      expect8(ctl_rdata == {2'b00, m_ctl}, "R11 ctl_rdata", ctl_rdata, {2'b00, m_ctl});
      expect8(per_valid == e_pv, "R3 per_valid", {7'd0, per_valid}, {7'd0, e_pv});
      expect8(per_room == (m_put_ok() && q.size() < 16), "R4 per_room",
              {7'd0, per_room}, {7'd0, m_put_ok() && q.size() < 16});
      if (e_pv) expect8(per_data == q[0], "R3 per_data", per_data, q[0]);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic hwr(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d; tick(); host_wr = 1'b0;
  endtask
  task automatic hrd();
    host_rd = 1'b1; tick(); host_rd = 1'b0;
  endtask
  task automatic ptake();
    per_take = 1'b1; tick(); per_take = 1'b0;
  endtask
  task automatic pput(input logic [7:0] d);
    per_put = 1'b1; per_put_data = d; tick(); per_put = 1'b0;
  endtask
  task automatic cwr(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d; tick(); ctl_we = 1'b0;
  endtask
  task automatic setmode(input logic [2:0] m);
    mode_sel = m; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 3'b000; ctl_we = 1'b0; ctl_wdata = 8'h00;
    host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    per_take = 1'b0; per_put = 1'b0; per_put_data = 8'h00; ack_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk_on = 1'b1;

    // R1 reset state
    expect8(fifo_empty == 1'b1, "R1 empty", {7'd0, fifo_empty}, 8'h01);
    expect8(fifo_full == 1'b0, "R1 full", {7'd0, fifo_full}, 8'h00);
    expect8(host_rdata == 8'h00, "R1 host_rdata", host_rdata, 8'h00);
    expect8(ctl_rdata == 8'h00, "R1 ctl_rdata", ctl_rdata, 8'h00);
    expect8({ack_irq, svc_irq} == 2'b00, "R1 irqs", {6'd0, ack_irq, svc_irq}, 8'h00);

    // R11 top bits read zero
    cwr(8'hFF);
    expect8(ctl_rdata == 8'h3F, "R11 ctl mask", ctl_rdata, 8'h3F);
    cwr(8'h20);

    // R2/R3 compat mode ignores direction=1
    setmode(3'b010);
    hwr(8'hA1); hwr(8'hA2); hwr(8'hA3);
    expect8(per_valid == 1'b1, "R2 compat forward", {7'd0, per_valid}, 8'h01);
    expect8(per_data == 8'hA1, "R3 head", per_data, 8'hA1);
    hrd();
    expect8(host_rdata == 8'h00, "R3 host_rd ignored", host_rdata, 8'h00);
    expect8(per_data == 8'hA1, "R3 head kept", per_data, 8'hA1);
    ptake();
    expect8(per_data == 8'hA2, "R3 order", per_data, 8'hA2);

    // R12 mode change flushes; R5 mode 000 takes nothing
    setmode(3'b000);
    expect8(fifo_empty == 1'b1, "R12 flush", {7'd0, fifo_empty}, 8'h01);
    hwr(8'h55);
    expect8(fifo_empty == 1'b1, "R5 spp no fifo", {7'd0, fifo_empty}, 8'h01);
    expect8(svc_irq == 1'b0, "R9 spp no svc", {7'd0, svc_irq}, 8'h00);

    // R4 ECP forward then reverse
    cwr(8'h00);
    setmode(3'b011);
    hwr(8'h11); hwr(8'h22);
    expect8(per_data == 8'h11, "R4 fwd head", per_data, 8'h11);
    ptake(); ptake();
    cwr(8'h20);
    for (int i = 0; i < 7; i++) pput(8'h40 + 8'(i));
    expect8(svc_irq == 1'b0, "R9 reverse below", {7'd0, svc_irq}, 8'h00);
    pput(8'h47);
    expect8(svc_irq == 1'b1, "R9 reverse at threshold", {7'd0, svc_irq}, 8'h01);
    hwr(8'hEE);
    for (int i = 0; i < 8; i++) begin
      hrd();
      expect8(host_rdata == 8'h40 + 8'(i), "R4 reverse read", host_rdata, 8'h40 + 8'(i));
    end
    expect8(fifo_empty == 1'b1, "R4 host_wr ignored", {7'd0, fifo_empty}, 8'h01);

    // R5/R6/R7 test mode
    cwr(8'h00);
    setmode(3'b110);
    for (int i = 0; i < 18; i++) hwr(8'h80 + 8'(i));
    expect8(fifo_full == 1'b1, "R6 full", {7'd0, fifo_full}, 8'h01);
    ptake();
    expect8(fifo_full == 1'b1, "R5 per_take no effect", {7'd0, fifo_full}, 8'h01);
    host_wr = 1'b1; host_wdata = 8'hCC; host_rd = 1'b1; tick();
    host_wr = 1'b0; host_rd = 1'b0;
    expect8(host_rdata == 8'h80, "R6 head intact", host_rdata, 8'h80);
    for (int i = 1; i < 16; i++) begin
      hrd();
      expect8(host_rdata == 8'h80 + 8'(i), "R6 contents", host_rdata, 8'h80 + 8'(i));
    end
    hrd(); hrd();
    expect8(host_rdata == 8'h8F, "R7 empty reread", host_rdata, 8'h8F);
    cwr(8'h20);
    hwr(8'h31); hrd();
    expect8(host_rdata == 8'h31, "R5 test reverse", host_rdata, 8'h31);

    // R10 acknowledge interrupt
    cwr(8'h10);
    ack_n = 1'b0; tick(); ack_n = 1'b1; tick();
    expect8(ack_irq == 1'b1, "R10 set", {7'd0, ack_irq}, 8'h01);
    tick();
    expect8(ack_irq == 1'b1, "R10 hold", {7'd0, ack_irq}, 8'h01);
    cwr(8'h00);
    expect8(ack_irq == 1'b0, "R10 clear", {7'd0, ack_irq}, 8'h00);
    ack_n = 1'b0; tick(); ack_n = 1'b1; tick();
    expect8(ack_irq == 1'b0, "R10 disabled", {7'd0, ack_irq}, 8'h00);

    repeat (3) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule